// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Path

This block takes the nibble stream of a 100 Mbit/s media-independent transmit interface and turns it into a single serial line bit plus a three-level line code for an external driver. A nibble period lasts five cycles of the block's bit clock. The block marks each period with a one-cycle nibble strobe. The source presents `txEn`, `txData` and `txErr` so that they are valid at the clock edge where that strobe is high.

Each sampled slot becomes a five-bit code group. Data nibbles go through a fixed 4-to-5 bit map. A frame opens with a two-group start delimiter and closes with a two-group end delimiter. Idle groups fill every slot in which no frame is active. A data slot with the error flag raised carries an error group instead of its nibble. The groups are shifted out most significant bit first. Each bit is XORed with a free-running LFSR keystream. A level tracker then follows the four-step MLT-3 cycle, one step per transmitted 1.

Top module: `fetx_symbol_path`

## Requirements
- R1: `nibbleStrobe` is high for exactly one cycle in every five, first after the fourth rising edge that follows reset release. Inputs are sampled only at an edge where it is high.
- R2: In a data slot, nibbles 0x0 to 0xF become 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101 respectively.
- R3: The slot in which `txEn` is first seen high while idle carries 11000, and the next slot carries 10001. The nibbles of both slots are dropped, and `txEn` and `txErr` are ignored in the second one.
- R4: The first slot of an open frame with `txEn` low carries 01101, and the next slot carries 00111 whatever the inputs. If `txEn` is high in the slot after that, a new frame starts there. Otherwise the slot is idle.
- R5: A data slot with `txErr` high carries 00100 in place of its nibble. `txErr` has no effect in idle or delimiter slots.
- R6: A group sampled at a strobe edge is sent over the next five edges, one bit per clock, leftmost bit first.
- R7: The keystream bit is s[10] XOR s[8] of an 11-bit state s that reset sets to all ones. s shifts left by one every clock, taking in the keystream bit. The line bit is the plain bit XOR the keystream bit.
- R8: The level code `mltLevel` steps through 00, 01, 00, 11 (zero, +1, zero, -1) in that order. It advances once for each line bit of 1 and holds for a 0. The value 10 never appears.
- R9: In reset, `serialBit` is 0, `mltLevel` is 00 and `nibbleStrobe` is 0. The plain bits sent before the first loaded group are 1s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, five cycles per nibble |
| rstN | input | 1 | Active-low asynchronous reset |
| txEn | input | 1 | Frame active, sampled at strobe edges |
| txData | input | 4 | Data nibble |
| txErr | input | 1 | Replace this data nibble by the error group |
| nibbleStrobe | output | 1 | Marks the edge at which inputs are taken |
| serialBit | output | 1 | Scrambled line bit |
| mltLevel | output | 2 | Three-level line code: 00 zero, 01 +1, 11 -1 |

## Verification
Two things happen at the same strobe edge. A new group is loaded into the shifter while the last bit of the previous group is still being sent. In the same slot, framing may have to close one frame and open the next. The bench provokes both by running frames back to back with `txEn` held high through the second end-delimiter slot, and by dropping `txEn` during the second start-delimiter slot. It descrambles every line bit with its own keystream and compares the result, cycle by cycle, with the group sequence it predicts from the slot inputs. Any lost or duplicated bit at a group boundary therefore shows up as a mismatch.

// File: rtl/fetx_pkg.sv
package fetx_pkg;

  typedef enum logic [2:0] {
    GRP_IDLE, GRP_SSD1, GRP_SSD2, GRP_ESD1, GRP_ESD2, GRP_DATA, GRP_ERR
  } grpSel_e;

  // strobes from framing control to the datapath
  typedef struct packed {
    logic    load;
    grpSel_e sel;
  } ctlStrobe_t;

  function automatic logic [4:0] mapNibble(input logic [3:0] nib);
    logic [4:0] code;
    case (nib)
      4'h0: code = 5'b11110;
      4'h1: code = 5'b01001;
      4'h2: code = 5'b10100;
      4'h3: code = 5'b10101;
      4'h4: code = 5'b01010;
      4'h5: code = 5'b01011;
      4'h6: code = 5'b01110;
      4'h7: code = 5'b01111;
      4'h8: code = 5'b10010;
      4'h9: code = 5'b10011;
      4'hA: code = 5'b10110;
      4'hB: code = 5'b10111;
      4'hC: code = 5'b11010;
      4'hD: code = 5'b11011;
      4'hE: code = 5'b11100;
      default: code = 5'b11101;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/fetx_ctl.sv
module fetx_ctl
  import fetx_pkg::*;
#(
  parameter int GRP_W = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  input  logic       txErr,
  output logic       nibbleStrobe,
  output ctlStrobe_t strobes
);
  localparam int PH_W = $clog2(GRP_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GRP_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START2, ST_DATA, ST_END2} frameSt_e;

  logic [PH_W-1:0] phase;
  frameSt_e        state, stateNext;
  grpSel_e         selNext;

  assign nibbleStrobe = (phase == PH_LAST);

  always_comb begin
    selNext   = GRP_IDLE;
    stateNext = state;
    case (state)
      ST_IDLE: if (txEn) begin
        selNext   = GRP_SSD1;
        stateNext = ST_START2;
      end
      ST_START2: begin
        selNext   = GRP_SSD2;
        stateNext = ST_DATA;
      end
      ST_DATA: if (txEn) begin
        selNext = txErr ? GRP_ERR : GRP_DATA;
      end else begin
        selNext   = GRP_ESD1;
        stateNext = ST_END2;
      end
      default: begin
        selNext   = GRP_ESD2;
        stateNext = ST_IDLE;
      end
    endcase
  end

  assign strobes = '{load: nibbleStrobe, sel: selNext};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      state <= ST_IDLE;
    end else begin
      phase <= nibbleStrobe ? '0 : phase + 1'b1;
      if (nibbleStrobe) state <= stateNext;
    end
  end

endmodule

// File: rtl/fetx_dp.sv
module fetx_dp
  import fetx_pkg::*;
#(
  parameter int              GRP_W    = 5,
  parameter int              NIB_W    = 4,
  parameter int              LFSR_W   = 11,
  parameter int              LFSR_TAP = 9,
  parameter logic [LFSR_W-1:0] SEED   = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobes,
  input  logic [NIB_W-1:0] txData,
  output logic             serialBit,
  output logic [1:0]       mltLevel
);
  logic [GRP_W-1:0]  shiftReg, grpCode;
  logic [LFSR_W-1:0] lfsr;
  logic [1:0]        mltPos;
  logic              keyBit, lineNext;

  always_comb begin
    case (strobes.sel)
      GRP_SSD1: grpCode = 5'b11000;
      GRP_SSD2: grpCode = 5'b10001;
      GRP_ESD1: grpCode = 5'b01101;
      GRP_ESD2: grpCode = 5'b00111;
      GRP_ERR:  grpCode = 5'b00100;
      GRP_DATA: grpCode = mapNibble(txData);
      default:  grpCode = 5'b11111;
    endcase
  end

  assign keyBit   = lfsr[LFSR_W-1] ^ lfsr[LFSR_TAP-1];
  assign lineNext = shiftReg[GRP_W-1] ^ keyBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '1;
      lfsr      <= SEED;
      serialBit <= 1'b0;
      mltPos    <= 2'd0;
    end else begin
      lfsr      <= {lfsr[LFSR_W-2:0], keyBit};
      serialBit <= lineNext;
      if (lineNext) mltPos <= mltPos + 2'd1;
      shiftReg  <= strobes.load ? grpCode : {shiftReg[GRP_W-2:0], 1'b1};
    end
  end

  always_comb begin
    case (mltPos)
      2'd1:    mltLevel = 2'b01;
      2'd3:    mltLevel = 2'b11;
      default: mltLevel = 2'b00;
    endcase
  end

endmodule

// File: rtl/fetx_symbol_path.sv
module fetx_symbol_path
  import fetx_pkg::*;
#(
  parameter int GRP_W    = 5,
  parameter int NIB_W    = 4,
  parameter int LFSR_W   = 11,
  parameter int LFSR_TAP = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEn,
  input  logic [NIB_W-1:0] txData,
  input  logic             txErr,
  output logic             nibbleStrobe,
  output logic             serialBit,
  output logic [1:0]       mltLevel
);
  ctlStrobe_t strobes;

  fetx_ctl #(.GRP_W(GRP_W)) ctl_i (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txErr(txErr),
    .nibbleStrobe(nibbleStrobe), .strobes(strobes)
  );

  fetx_dp #(.GRP_W(GRP_W), .NIB_W(NIB_W), .LFSR_W(LFSR_W),
            .LFSR_TAP(LFSR_TAP), .SEED('1)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txData(txData),
    .serialBit(serialBit), .mltLevel(mltLevel)
  );

endmodule

// File: rtl/fetx_symbol_path_chk.sv
module fetx_symbol_path_chk #(
  parameter int GRP_W = 5
) (
  input logic       clk,
  input logic       rstN,
  input logic       nibbleStrobe,
  input logic       serialBit,
  input logic [1:0] mltLevel
);
  localparam int PH_W = $clog2(GRP_W);
  logic [PH_W-1:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gap <= '0;
    else       gap <= nibbleStrobe ? '0 : gap + 1'b1;
  end

  // R1: strobe exactly every GRP_W cycles
  assert_strobe_period_R1: assert property (@(posedge clk) disable iff (!rstN)
    nibbleStrobe == (gap == PH_W'(GRP_W - 1)));

  assert_level_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    mltLevel != 2'b10);

  assert_hold_on_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !serialBit |-> $stable(mltLevel));

  assert_step_on_one_R8: assert property (@(posedge clk) disable iff (!rstN)
    serialBit |-> !$stable(mltLevel));

  assert_back_to_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mltLevel != 2'b00) |=> (mltLevel == $past(mltLevel) || mltLevel == 2'b00));

endmodule

bind fetx_symbol_path fetx_symbol_path_chk #(.GRP_W(GRP_W)) chk_i (
  .clk(clk), .rstN(rstN), .nibbleStrobe(nibbleStrobe),
  .serialBit(serialBit), .mltLevel(mltLevel)
);

// File: tb/fetx_symbol_path_tb.sv
`timescale 1ns/1ps
module fetx_symbol_path_tb_top;
  logic clk = 1'b0, rstN = 1'b0, txEn = 1'b0, txErr = 1'b0;
  logic [3:0] txData = 4'h0;
  logic nibbleStrobe, serialBit;
  logic [1:0] mltLevel;

  fetx_symbol_path dut_i (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txData(txData), .txErr(txErr),
    .nibbleStrobe(nibbleStrobe), .serialBit(serialBit), .mltLevel(mltLevel)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef struct { bit en; bit er; logic [3:0] d; } slot_t;
  slot_t plan[$];
  bit    bitQ[$];
  string tagQ[$];

  function automatic logic [4:0] dataCode(input int n);
    case (n)
      0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;
      3: return 5'b10101;  4: return 5'b01010;  5: return 5'b01011;
      6: return 5'b01110;  7: return 5'b01111;  8: return 5'b10010;
      9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
      12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100;
      default: return 5'b11101;
    endcase
  endfunction

  function automatic logic [1:0] levelOf(input int p);
    return (p == 1) ? 2'b01 : (p == 3) ? 2'b11 : 2'b00;
  endfunction

  task automatic pushGroup(input logic [4:0] g, input string tag);
    for (int i = 4; i >= 0; i--) begin
      bitQ.push_back(g[i]);
      tagQ.push_back(tag);
    end
  endtask

  task automatic addSlot(input bit en, input bit er, input logic [3:0] d);
    slot_t s;
    s.en = en; s.er = er; s.d = d;
    plan.push_back(s);
  endtask

  initial begin
    int phase = 0, pos = 0, frame = 0, tail = 0;
    logic [10:0] lfsr = 11'h7FF;
    int lcg = 7;
    // stimulus
    repeat (3) addSlot(0, 0, 4'h0);
    addSlot(1, 0, 4'h5); addSlot(1, 1, 4'h6);              // start slots, R3 R5 ignored
    for (int n = 0; n < 16; n++) addSlot(1, 0, 4'(n));      // R2 all nibbles
    addSlot(0, 1, 4'h0); addSlot(0, 0, 4'h0);              // R4 end, err ignored
    addSlot(0, 1, 4'h3);                                   // idle with err, R5
    addSlot(1, 0, 4'h1); addSlot(1, 0, 4'h2);
    addSlot(1, 0, 4'h9); addSlot(1, 1, 4'hA); addSlot(1, 0, 4'hB); // R5 error
    addSlot(0, 0, 4'h0); addSlot(1, 0, 4'h4);              // R4 txEn high in second end slot
    addSlot(1, 0, 4'h7); addSlot(1, 0, 4'h8);              // back-to-back start
    addSlot(1, 0, 4'hC); addSlot(0, 0, 4'h0); addSlot(0, 0, 4'h0);
    addSlot(1, 0, 4'h1); addSlot(0, 0, 4'h0);              // drop during second start slot
    repeat (3) addSlot(0, 0, 4'h0);
    addSlot(1, 0, 4'h0); addSlot(1, 0, 4'h0);
    for (int n = 0; n < 40; n++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      addSlot(1, (n % 13) == 6, 4'(lcg >> 16));
    end
    repeat (4) addSlot(0, 0, 4'h0);

    // reset, R9
    repeat (3) @(negedge clk);
    check(serialBit == 1'b0, "R9", "reset serialBit", int'(serialBit), 0);
    check(mltLevel == 2'b00, "R9", "reset mltLevel", int'(mltLevel), 0);
    check(nibbleStrobe == 1'b0, "R9", "reset nibbleStrobe", int'(nibbleStrobe), 0);
    rstN = 1'b1;
    pushGroup(5'b11111, "R9");

    while (tail < 30) begin
      bit b, key, strobeBefore;
      string tag;
      @(negedge clk);
      strobeBefore = (phase == 4);
      b   = bitQ.pop_front();
      tag = tagQ.pop_front();
      key = lfsr[10] ^ lfsr[8];
      lfsr = {lfsr[9:0], key};
      if (b ^ key) pos = (pos + 1) % 4;
      if (strobeBefore) begin
        case (frame)
          0: if (txEn) begin pushGroup(5'b11000, "R3"); frame = 1; end
             else pushGroup(5'b11111, "R4");
          1: begin pushGroup(5'b10001, "R3"); frame = 2; end
          2: if (!txEn) begin pushGroup(5'b01101, "R4"); frame = 3; end
             else if (txErr) pushGroup(5'b00100, "R5");
             else pushGroup(dataCode(int'(txData)), "R2");
          default: begin pushGroup(5'b00111, "R4"); frame = 0; end
        endcase
      end
      phase = (phase + 1) % 5;
      // descramble the line bit and compare with the predicted plain bit (R6 R7)
      check((serialBit ^ key) == b, tag, "R6 R7 descrambled bit",
            int'(serialBit ^ key), int'(b));
      check(mltLevel == levelOf(pos), "R8", "mltLevel", int'(mltLevel), int'(levelOf(pos)));
      check(nibbleStrobe == (phase == 4), "R1", "nibbleStrobe",
            int'(nibbleStrobe), int'(phase == 4));
      if (phase == 4) begin
        if (plan.size() > 0) begin
          slot_t s;
          s = plan.pop_front();
          txEn = s.en; txErr = s.er; txData = s.d;
        end else begin
          txEn = 1'b0; txErr = 1'b0; txData = 4'h0;
        end
      end
      if (plan.size() == 0) tail++;
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule